// File: doc/BRIEF.md
# Pointer Generation Barrier Checker

The block sits beside the memory-access path and decides, for every request, whether the access may proceed or must trap to software. Every pointer carries a three-bit collector tag in its top three bits. A software-written access mask holds one bit per tag value. A load, or a store of plain data, traps when the bit selected by the address tag is set. When a store writes a pointer, the tag of the value and the tag of the destination address together select one bit of a 64-bit store mask. A collector can use this to catch stores that place a young pointer into an older region, without stopping the program.

The decision is registered. One cycle after a request, exactly one of two outputs goes high: the proceed strobe or the trap. When a trap is raised, the mask index that caused it is reported beside it. Both masks clear at reset, so no access traps until software arms them. A separate combinational comparator tests two pointers for equality and ignores their tag bits.

Top module: `gcb_checker`

## Requirements
- R1: While reset is low, and on the first cycle after it, `acc_go`, `acc_trap` and `trap_idx` are zero. Both masks reset to all zeros, so before any mask write every request proceeds and none traps.
- R2: A request with `req_is_store`=0 traps when access-mask bit `req_addr_tag` is set. Otherwise it proceeds.
- R3: A request with `req_is_store`=1 and `req_ptr_val`=1 traps when store-mask bit `req_data_tag*8 + req_addr_tag` is set. Otherwise it proceeds. The data tag is the high half of the index and the address tag is the low half.
- R4: A store with `req_ptr_val`=0 checks only `req_addr_tag` against the access mask and ignores `req_data_tag`. A load ignores `req_ptr_val` and `req_data_tag`.
- R5: The result of a request appears on the clock edge after it. For each request with `req_valid`=1, exactly one of `acc_go` and `acc_trap` is high for one cycle. With no request, both are low.
- R6: When `acc_trap` is high, `trap_idx` holds the mask bit index that caused it. For an access-mask trap this is the 3-bit tag zero-extended to 6 bits. For a store-mask trap it is the 6-bit store index. `trap_idx` is zero when `acc_trap` is low.
- R7: A write with `cfg_we`=1 and `cfg_sel`=0 loads the access mask from `cfg_wdata[7:0]`. A write with `cfg_sel`=1 loads the store mask from `cfg_wdata[63:0]`, where bit i is store index i. The new mask applies to requests from the next cycle on. A request presented in the same cycle as the write is checked against the old mask.
- R8: `cmp_eq` is 1 exactly when bits [60:0] of `cmp_a` and `cmp_b` match. Bits [63:61] have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | 0 selects the access mask, 1 selects the store mask |
| cfg_wdata | input | 64 | Mask write data |
| req_valid | input | 1 | A memory request is presented |
| req_is_store | input | 1 | The request is a store |
| req_ptr_val | input | 1 | The stored value is a pointer |
| req_addr_tag | input | 3 | Collector tag: top three bits of the access address |
| req_data_tag | input | 3 | Collector tag: top three bits of the stored value |
| acc_go | output | 1 | Registered: the request may complete |
| acc_trap | output | 1 | Registered: the request traps to software |
| trap_idx | output | 6 | Registered mask index that raised the trap |
| cmp_a | input | 64 | First pointer operand of the comparator |
| cmp_b | input | 64 | Second pointer operand of the comparator |
| cmp_eq | output | 1 | Pointers equal, ignoring tag bits |

## Verification
The masks are the only hidden state. A wrong or stale mask bit stays invisible until a request lands on that exact index. It then shows, one cycle later, as a trap where the access should proceed, or the reverse, along with the index on `trap_idx`. The stimulus therefore walks every access index and every store index after directed writes. It places requests in the same cycle as mask writes, and it mixes random traffic, so a bit stuck, swapped between the halves of the index, or updated a cycle early shows up within a cycle of the first request that touches it.

// File: rtl/gcb_pkg.sv
// Package: shared sizes and the mask-select encoding for the barrier checker.
// Assumes the collector tag occupies the top TAG_W bits of a pointer.
package gcb_pkg;
    localparam int PTR_W = 64;
    localparam int TAG_W = 3;
    localparam int ACC_N = 2 ** TAG_W;
    localparam int ST_N  = 2 ** (2 * TAG_W);
    localparam int IDX_W = 2 * TAG_W;

    typedef enum logic {
        CFG_ACC = 1'b0,
        CFG_ST  = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/gcb_mask_regs.sv
// Module: holds the access mask and the store mask.
// Assumes one write per cycle. The write data is ST_N bits wide, and the
// access mask takes its low ACC_N bits. Both masks clear on reset.
module gcb_mask_regs #(
    parameter int ACC_N = gcb_pkg::ACC_N,
    parameter int ST_N  = gcb_pkg::ST_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [ST_N-1:0]  cfg_wdata,
    output logic [ACC_N-1:0] acc_mask,
    output logic [ST_N-1:0]  st_mask
);
    import gcb_pkg::*;

    // Access mask register: load on a write to the access mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_mask <= '0;
        else if (cfg_we && cfg_sel == CFG_ACC)
            acc_mask <= cfg_wdata[ACC_N-1:0];
    end

    // Store mask register: load on a write to the store mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_mask <= '0;
        else if (cfg_we && cfg_sel == CFG_ST)
            st_mask <= cfg_wdata;
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(acc_mask) && $stable(st_mask))); // R7
endmodule

// File: rtl/gcb_index_gen.sv
// Module: forms the mask index for a request and looks up the trap bit.
// Assumes ptr_store is already qualified with the store flag. Purely
// combinational. Plain accesses use the address tag zero-extended.
module gcb_index_gen #(
    parameter int TAG_W = gcb_pkg::TAG_W,
    localparam int ACC_N = 2 ** TAG_W,
    localparam int ST_N  = 2 ** (2 * TAG_W),
    localparam int IDX_W = 2 * TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_store,
    input  logic [TAG_W-1:0] addr_tag,
    input  logic [TAG_W-1:0] data_tag,
    input  logic [ACC_N-1:0] acc_mask,
    input  logic [ST_N-1:0]  st_mask,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    // Index selection: concatenated tags for pointer stores, address tag otherwise.
    always_comb begin
        if (ptr_store)
            idx = {data_tag, addr_tag};
        else
            idx = {{TAG_W{1'b0}}, addr_tag};
    end

    // Mask lookup: the selected mask bit decides the trap.
    always_comb begin
        if (ptr_store)
            hit = st_mask[idx];
        else
            hit = acc_mask[idx[TAG_W-1:0]];
    end

    AST_ACC_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_store |-> (idx < IDX_W'(ACC_N))); // R6
endmodule

// File: rtl/gcb_ptr_cmp.sv
// Module: compares two pointers for equality and ignores the top TAG_W
// collector bits. Purely combinational.
module gcb_ptr_cmp #(
    parameter int PTR_W = gcb_pkg::PTR_W,
    parameter int TAG_W = gcb_pkg::TAG_W,
    localparam int PAY_W = PTR_W - TAG_W
) (
    input  logic [PTR_W-1:0] a,
    input  logic [PTR_W-1:0] b,
    output logic             eq
);
    logic [PAY_W-1:0] diff;

    // Bitwise difference of the untagged payload.
    genvar gi;
    generate
        for (gi = 0; gi < PAY_W; gi++) begin : g_bit
            assign diff[gi] = a[gi] ^ b[gi];
        end
    endgenerate

    // Reduction: equal when no payload bit differs.
    always_comb eq = ~|diff;

    // Identical operands must always compare equal.
    always_comb begin
        if (a == b)
            AST_EQ_REFLEX: assert (eq); // R8
    end
endmodule

// File: rtl/gcb_checker.sv
// Module: top of the pointer generation barrier checker. It registers the
// proceed or trap decision one cycle after each request and reports the
// index that trapped. It also provides a tag-blind pointer comparator.
// Assumes a request that is not a store ignores req_ptr_val.
module gcb_checker #(
    parameter int PTR_W = gcb_pkg::PTR_W,
    parameter int TAG_W = gcb_pkg::TAG_W,
    localparam int ACC_N = 2 ** TAG_W,
    localparam int ST_N  = 2 ** (2 * TAG_W),
    localparam int IDX_W = 2 * TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [ST_N-1:0]  cfg_wdata,
    input  logic             req_valid,
    input  logic             req_is_store,
    input  logic             req_ptr_val,
    input  logic [TAG_W-1:0] req_addr_tag,
    input  logic [TAG_W-1:0] req_data_tag,
    output logic             acc_go,
    output logic             acc_trap,
    output logic [IDX_W-1:0] trap_idx,
    input  logic [PTR_W-1:0] cmp_a,
    input  logic [PTR_W-1:0] cmp_b,
    output logic             cmp_eq
);
    logic [ACC_N-1:0] acc_mask;
    logic [ST_N-1:0]  st_mask;
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic             ptr_store;

    // Qualify the pointer flag with the store flag.
    always_comb ptr_store = req_is_store & req_ptr_val;

    gcb_mask_regs #(.ACC_N(ACC_N), .ST_N(ST_N)) u_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .acc_mask  (acc_mask),
        .st_mask   (st_mask)
    );

    gcb_index_gen #(.TAG_W(TAG_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_store (ptr_store),
        .addr_tag  (req_addr_tag),
        .data_tag  (req_data_tag),
        .acc_mask  (acc_mask),
        .st_mask   (st_mask),
        .idx       (idx),
        .hit       (hit)
    );

    gcb_ptr_cmp #(.PTR_W(PTR_W), .TAG_W(TAG_W)) u_cmp (
        .a  (cmp_a),
        .b  (cmp_b),
        .eq (cmp_eq)
    );

    // Decision register: proceed or trap one cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_go   <= 1'b0;
            acc_trap <= 1'b0;
            trap_idx <= '0;
        end else begin
            acc_go   <= req_valid & ~hit;
            acc_trap <= req_valid & hit;
            trap_idx <= (req_valid && hit) ? idx : '0;
        end
    end

    AST_GO_TRAP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_go && acc_trap)); // R5
    AST_REQ_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (acc_go || acc_trap)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!acc_go && !acc_trap)); // R5
    AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_trap |-> (trap_idx == '0)); // R6
endmodule

// File: tb/gcb_checker_tb.sv
// Bench: a behavioural reference model of both masks, compared on every clock.
module gcb_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_sel;
    logic [63:0] cfg_wdata;
    logic        req_valid, req_is_store, req_ptr_val;
    logic [2:0]  req_addr_tag, req_data_tag;
    logic        acc_go, acc_trap, cmp_eq;
    logic [5:0]  trap_idx;
    logic [63:0] cmp_a, cmp_b;

    integer checks = 0;
    integer errors = 0;

    logic [7:0]  m_acc;
    logic [63:0] m_st;

    always #5 clk = ~clk;

    gcb_checker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_ptr_val(req_ptr_val), .req_addr_tag(req_addr_tag),
        .req_data_tag(req_data_tag), .acc_go(acc_go), .acc_trap(acc_trap),
        .trap_idx(trap_idx), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_eq(cmp_eq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive the inputs, predict, clock, compare.
    task automatic step(input logic rst, input logic we, input logic sel,
                        input logic [63:0] wd, input logic v, input logic st,
                        input logic pv, input logic [2:0] at, input logic [2:0] dt,
                        input string req);
        logic       hit, ps;
        logic [5:0] ix;
        logic       e_go, e_tr;
        logic [5:0] e_ix;
        rst_n = rst; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        req_valid = v; req_is_store = st; req_ptr_val = pv;
        req_addr_tag = at; req_data_tag = dt;
        ps  = st && pv;
        ix  = ps ? (int'(dt) * 8 + int'(at)) : int'(at);
        hit = ps ? m_st[ix] : m_acc[at];
        e_go = rst && v && !hit;
        e_tr = rst && v && hit;
        e_ix = e_tr ? ix : 6'd0;
        if (!rst) begin
            m_acc = '0; m_st = '0;
        end else if (we) begin
            if (sel) m_st = wd; else m_acc = wd[7:0];
        end
        @(posedge clk); #1;
        chk({req, " go"}, acc_go, e_go);
        chk({req, " trap"}, acc_trap, e_tr);
        chk({req, " idx"}, trap_idx, e_ix);
    endtask

    initial begin
        #1500000;
        errors = errors + 1;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_acc = '0; m_st = '0;
        cmp_a = '0; cmp_b = '0;
        @(posedge clk); #1;
        // R1: reset holds the outputs low even with a request present.
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 reset");
        // R1: masks are cleared, so every index proceeds.
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, 0, 3'(i), 0, "R1 clear acc");
        for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 1, 1, 1, 3'(i % 8), 3'(i / 8), "R1 clear st");
        // R7: a request in the same cycle as the write still sees the old mask.
        step(1, 1, 0, 64'h0000_0000_0000_00A5, 1, 0, 0, 3'd0, 0, "R7 same-cycle");
        // R2: walk the access mask.
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, 0, 3'(i), 0, "R2 walk");
        // R4: a load with the pointer flag set, and a non-pointer store, both use the access mask.
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, 1, 3'(i), 3'(7 - i), "R4 load ptrflag");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 1, 0, 3'(i), 3'(i + 3), "R4 plain store");
        // R3: a store-mask pattern that separates the two halves of the index.
        step(1, 1, 1, 64'h8000_0000_0000_0102, 0, 0, 0, 0, 0, "R7 st write");
        for (int i = 0; i < 64; i++) step(1, 0, 0, 0, 1, 1, 1, 3'(i % 8), 3'(i / 8), "R3 walk");
        // R6: the trap index reports the full store index.
        step(1, 0, 0, 0, 1, 1, 1, 3'd7, 3'd7, "R6 idx 63");
        // R5: idle cycles raise nothing.
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 1, 1, 3'd7, 3'd7, "R5 idle");
        // R8: the comparator ignores the tag bits.
        cmp_a = 64'h1234_5678_9ABC_DEF0; cmp_b = cmp_a ^ 64'hE000_0000_0000_0000; #1;
        chk("R8 tag blind", cmp_eq, 1'b1);
        cmp_b = cmp_a ^ 64'h1000_0000_0000_0000; #1;
        chk("R8 bit60", cmp_eq, 1'b0);
        cmp_b = cmp_a ^ 64'h1; #1;
        chk("R8 bit0", cmp_eq, 1'b0);
        // Random traffic mixed with mask writes (R2 R3 R5 R7).
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] wd;
            wd = {$urandom, $urandom};
            step(1, ($urandom % 16) == 0, $urandom % 2, wd, $urandom % 4 != 0,
                 $urandom % 2, $urandom % 2, 3'($urandom), 3'($urandom), "R5 random");
            cmp_a = {$urandom, $urandom};
            cmp_b = ($urandom % 2) ? {3'($urandom), cmp_a[60:0]} : {$urandom, $urandom};
            #1;
            chk("R8 random", cmp_eq, cmp_a[60:0] == cmp_b[60:0]);
        end
        // R1: a second reset clears both masks again.
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R1 re-reset");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 1, 1, 3'(i), 3'(i), "R1 after reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule